// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Power-Off Request

This block keeps a free-running real-time count that advances once for every pulse of a 32.768 kHz tick enable. The tick enable is a strobe synchronous to the system clock. Software sees the count through a simple 32-bit register bus as two words. One word holds the upper bits of the count. The other holds the lower 32 bits. Software may rewrite either word on its own. When it does, the other half keeps the value it has at that moment.

A low-power control word sits next to the count. It stores whatever is written to it and returns it on read. A write to this word that sets both the turn-off bit and the power-off enable bit raises a one-cycle shutdown request for the system's power controller.

Reads are registered. Read data is presented in the cycle after the read strobe. It is zero in any cycle that does not follow a read.

Top module: `lp_rtc_ctrl`

## Requirements
- R1: In a cycle with the tick enable high and no counter write, the counter grows by exactly one, and a carry out of bit 31 reaches bit 32. The value 2^CNT_W-1 wraps to zero.
- R2: A read of byte offset 0x050 returns counter bits CNT_W-1:32 in data bits CNT_W-33:0. All higher data bits read as zero.
- R3: A read of byte offset 0x054 returns counter bits 31:0. Every read result appears on the read data port in the cycle after the read strobe, and the port is zero in any cycle that does not follow a read.
- R4: A write to offset 0x050 loads counter bits CNT_W-1:32 from write data bits CNT_W-33:0. Counter bits 31:0 keep their current value.
- R5: A write to offset 0x054 loads counter bits 31:0 from the write data. The upper counter bits keep their current value.
- R6: When a counter write and a tick fall in the same cycle, the written value is taken and that tick is dropped.
- R7: A write to offset 0x038 stores the full 32-bit word, and a later read of 0x038 returns it unchanged.
- R8: A write to 0x038 with bit 6 (turn-off) and bit 5 (power-off enable) both set drives the shutdown request high for exactly the next cycle. Any other write to 0x038 leaves it low.
- R9: Reads of any other offset return zero. Writes to any other offset change neither the counter nor the control word, and never raise the shutdown request.
- R10: After synchronous reset, the counter is zero, the control word is zero, the read data is zero and no shutdown request is pending.
- R11: A read issued in the same cycle as a write or a tick returns the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz time-base strobe, one clock cycle wide |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle after the read strobe |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The bench builds the block with a counter width of 36 bits instead of 47, leaving only four upper bits. With that width it can sweep every value of the high word. For each value it parks the low word one tick below its carry, so every increment from one high value to the next is observed. The sweep ends in the full wrap from all ones to zero. The control word is driven with every combination of the two power-off bits, with surrounding bits both set and clear, and the same pattern is written to unmapped offsets to show that it has no effect there.

// File: rtl/lp_rtc_pkg.sv
`timescale 1ns/1ps
// Package: shared register-select type for the low-power counter block.
// Assumes a single bus address selects at most one register.
package lp_rtc_pkg;
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_CNT_HI = 2'd2,
        SEL_CNT_LO = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/lp_rtc_decode.sv
`timescale 1ns/1ps
// Module: lp_rtc_decode
// Maps a byte offset to a register select. Unmapped offsets select none.
// Assumes the three offsets are distinct.
module lp_rtc_decode
    import lp_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFF_CTRL   = 8'h38,
    parameter logic [ADDR_W-1:0] OFF_CNT_HI = 8'h50,
    parameter logic [ADDR_W-1:0] OFF_CNT_LO = 8'h54
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Compare the offset against each mapped register.
    always_comb begin
        if (addr == OFF_CTRL)        sel = SEL_CTRL;
        else if (addr == OFF_CNT_HI) sel = SEL_CNT_HI;
        else if (addr == OFF_CNT_LO) sel = SEL_CNT_LO;
        else                         sel = SEL_NONE;
    end
endmodule

// File: rtl/lp_rtc_counter.sv
`timescale 1ns/1ps
// Module: lp_rtc_counter
// Holds the real-time count. A half write replaces one half and keeps the
// other half's current value; a write takes priority over a tick.
// Assumes DATA_W < CNT_W <= 2*DATA_W and that wr_hi and wr_lo are exclusive.
module lp_rtc_counter #(
    parameter int CNT_W  = 47,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q
);
    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [HI_W-1:0]   hi_part;
    logic [DATA_W-1:0] lo_part;

    // Split the present count so both halves come from the same instant.
    always_comb begin
        hi_part = cnt_q[CNT_W-1:DATA_W];
        lo_part = cnt_q[DATA_W-1:0];
    end

    // Counter state: reset, partial loads, then the tick increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_hi) begin
            cnt_q <= {wdata[HI_W-1:0], lo_part};
        end else if (wr_lo) begin
            cnt_q <= {hi_part, wdata};
        end else if (tick_en) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end
endmodule

// File: rtl/lp_rtc_ctrl_reg.sv
`timescale 1ns/1ps
// Module: lp_rtc_ctrl_reg
// Stores the low-power control word and raises a one-cycle shutdown request
// for each written word that carries both the turn-off and enable bits.
// Assumes OFF_BIT and EN_BIT are distinct positions below DATA_W.
module lp_rtc_ctrl_reg #(
    parameter int DATA_W  = 32,
    parameter int OFF_BIT = 6,
    parameter int EN_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              shut_q
);
    logic power_off_word;

    // Detect the power-off bit combination in the incoming word.
    always_comb power_off_word = wdata[OFF_BIT] & wdata[EN_BIT];

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata;
    end

    // Shutdown pulse: high for the single cycle after a qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) shut_q <= 1'b0;
        else        shut_q <= wr_ctrl & power_off_word;
    end
endmodule

// File: rtl/lp_rtc_ctrl.sv
`timescale 1ns/1ps
// Module: lp_rtc_ctrl (top)
// Register-mapped real-time counter with a low-power control word.
// Assumes one access address per cycle; read and write may share it.
// Read data is registered and zero when no read was issued.
module lp_rtc_ctrl
    import lp_rtc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 47,
    parameter int OFF_BIT = 6,
    parameter int EN_BIT  = 5,
    parameter logic [ADDR_W-1:0] OFF_CTRL   = 8'h38,
    parameter logic [ADDR_W-1:0] OFF_CNT_HI = 8'h50,
    parameter logic [ADDR_W-1:0] OFF_CNT_LO = 8'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              shutdown_req
);
    localparam int HI_W  = CNT_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;

    reg_sel_e          sel;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_hi;
    logic              wr_lo;
    logic              wr_ctrl;

    lp_rtc_decode #(
        .ADDR_W    (ADDR_W),
        .OFF_CTRL  (OFF_CTRL),
        .OFF_CNT_HI(OFF_CNT_HI),
        .OFF_CNT_LO(OFF_CNT_LO)
    ) decode_i (
        .addr(bus_addr),
        .sel (sel)
    );

    // Qualify the write strobe with the register select.
    always_comb begin
        wr_hi   = bus_wr && (sel == SEL_CNT_HI);
        wr_lo   = bus_wr && (sel == SEL_CNT_LO);
        wr_ctrl = bus_wr && (sel == SEL_CTRL);
    end

    lp_rtc_counter #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
    ) counter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .wr_hi  (wr_hi),
        .wr_lo  (wr_lo),
        .wdata  (bus_wdata),
        .cnt_q  (cnt_q)
    );

    lp_rtc_ctrl_reg #(
        .DATA_W (DATA_W),
        .OFF_BIT(OFF_BIT),
        .EN_BIT (EN_BIT)
    ) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(wr_ctrl),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .shut_q (shutdown_req)
    );

    // Read multiplexer over the pre-edge register values.
    always_comb begin
        unique case (sel)
            SEL_CTRL:   rd_next = ctrl_q;
            SEL_CNT_HI: rd_next = {{PAD_W{1'b0}}, cnt_q[CNT_W-1:DATA_W]};
            SEL_CNT_LO: rd_next = cnt_q[DATA_W-1:0];
            default:    rd_next = '0;
        endcase
    end

    // Registered read data, cleared in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_next;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/lp_rtc_ctrl_chk.sv
`timescale 1ns/1ps
// Module: lp_rtc_ctrl_chk
// Property checker for lp_rtc_ctrl, attached by bind. Observes the ports and
// the internal count; drives nothing.
module lp_rtc_ctrl_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 47,
    parameter int OFF_BIT = 6,
    parameter int EN_BIT  = 5,
    parameter logic [ADDR_W-1:0] OFF_CTRL   = 8'h38,
    parameter logic [ADDR_W-1:0] OFF_CNT_HI = 8'h50,
    parameter logic [ADDR_W-1:0] OFF_CNT_LO = 8'h54
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              shutdown_req,
    input logic [CNT_W-1:0]  cnt
);
    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic cnt_wr;
    logic hi_wr;
    logic lo_wr;
    logic pwr_wr;

    // Classify the current bus access independently of the design's decode.
    always_comb begin
        hi_wr  = bus_wr && (bus_addr == OFF_CNT_HI);
        lo_wr  = bus_wr && (bus_addr == OFF_CNT_LO);
        cnt_wr = hi_wr || lo_wr;
        pwr_wr = bus_wr && (bus_addr == OFF_CTRL)
                 && bus_wdata[OFF_BIT] && bus_wdata[EN_BIT];
    end

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr) |=> (cnt == $past(cnt) + ONE)); // R1

    AST_HI_READ_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_CNT_HI) |=> (bus_rdata[DATA_W-1:HI_W] == '0)); // R2

    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R3

    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0])
                   && cnt[CNT_W-1:DATA_W] == $past(bus_wdata[HI_W-1:0]))); // R4

    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W])
                   && cnt[DATA_W-1:0] == $past(bus_wdata))); // R5, R6

    AST_SHUT_ON_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_wr |=> shutdown_req); // R8

    AST_SHUT_ONLY_AFTER_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_wr |=> !shutdown_req); // R8, R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_wr) |=> $stable(cnt)); // R9
endmodule

bind lp_rtc_ctrl lp_rtc_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .OFF_BIT   (OFF_BIT),
    .EN_BIT    (EN_BIT),
    .OFF_CTRL  (OFF_CTRL),
    .OFF_CNT_HI(OFF_CNT_HI),
    .OFF_CNT_LO(OFF_CNT_LO)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .shutdown_req(shutdown_req),
    .cnt         (cnt_q)
);

// File: tb/lp_rtc_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for lp_rtc_ctrl built with a 36-bit counter. Each access is driven at
// the falling edge. Outputs are compared at the next falling edge against a
// model computed from the requirements.
module lp_rtc_ctrl_tb_top;
    localparam int TB_CNT_W = 36;
    localparam int TB_HI_W  = TB_CNT_W - 32;
    localparam logic [7:0] A_CTRL = 8'h38;
    localparam logic [7:0] A_HI   = 8'h50;
    localparam logic [7:0] A_LO   = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        shutdown_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [TB_CNT_W-1:0] m_cnt = '0;
    logic [31:0]         m_ctrl = '0;

    always #5 clk = ~clk;

    lp_rtc_ctrl #(.CNT_W(TB_CNT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .shutdown_req(shutdown_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle; the model supplies the expected read data and pulse.
    task automatic step(input logic t, input logic w, input logic r,
                        input logic [7:0] a, input logic [31:0] d, input string req);
        logic [31:0] exp_rd;
        logic        exp_sh;
        exp_rd = '0;
        if (r) begin
            if (a == A_HI)        exp_rd = {{(32-TB_HI_W){1'b0}}, m_cnt[TB_CNT_W-1:32]};
            else if (a == A_LO)   exp_rd = m_cnt[31:0];
            else if (a == A_CTRL) exp_rd = m_ctrl;
        end
        exp_sh = w && (a == A_CTRL) && d[6] && d[5];
        if (w && a == A_HI)      m_cnt = {d[TB_HI_W-1:0], m_cnt[31:0]};
        else if (w && a == A_LO) m_cnt = {m_cnt[TB_CNT_W-1:32], d};
        else if (t)              m_cnt = m_cnt + 1'b1;
        if (w && a == A_CTRL) m_ctrl = d;
        tick_en = t; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        check({req, " rdata"}, bus_rdata, exp_rd);
        check({req, " shutdown"}, {31'd0, shutdown_req}, {31'd0, exp_sh});
        tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset rdata", bus_rdata, 32'd0);
        check("R10 reset shutdown", {31'd0, shutdown_req}, 32'd0);
        rst_n = 1'b1;
        step(0, 0, 1, A_HI, 0, "R10 hi after reset");
        step(0, 0, 1, A_LO, 0, "R10 lo after reset");
        step(0, 0, 1, A_CTRL, 0, "R10 ctrl after reset");

        // R1 / R11: ticks with a read in the same cycle return the old value
        for (int i = 0; i < 6; i++) step(1, 0, 1, A_LO, 0, "R1 R11 tick read");
        step(0, 0, 0, A_LO, 0, "R3 idle zero");

        // R4 R5 R1 R2: sweep every high value across the low-word carry
        for (int h = 0; h < (1 << TB_HI_W); h++) begin
            step(0, 1, 0, A_HI, 32'hABCD_E000 | h, "R4 hi write");
            step(0, 0, 1, A_LO, 0, "R4 lo kept");
            step(0, 1, 0, A_LO, 32'hFFFF_FFFF, "R5 lo write");
            step(0, 0, 1, A_HI, 0, "R5 R2 hi kept");
            step(1, 0, 0, A_LO, 0, "R1 carry tick");
            step(0, 0, 1, A_LO, 0, "R1 lo after carry");
            step(0, 0, 1, A_HI, 0, "R1 R2 hi after carry");
        end

        // R6: counter write with a simultaneous tick
        step(1, 1, 0, A_LO, 32'h1234_5678, "R6 lo write vs tick");
        step(0, 0, 1, A_LO, 0, "R6 lo value");
        step(1, 1, 0, A_HI, 32'h0000_0007, "R6 hi write vs tick");
        step(0, 0, 1, A_HI, 0, "R6 hi value");
        step(0, 0, 1, A_LO, 0, "R6 lo untouched");

        // R11: read during a write returns the old word
        step(0, 1, 1, A_LO, 32'h0BAD_F00D, "R11 read during write");
        step(0, 0, 1, A_LO, 0, "R11 new value");

        // R7 R8: control word patterns and the power-off pulse
        for (int p = 0; p < 4; p++) begin
            logic [31:0] hi_fill;
            hi_fill = (p[0]) ? 32'hFFFF_FF9F : 32'h0000_0000;
            for (int b = 0; b < 4; b++) begin
                step(0, 1, 0, A_CTRL, hi_fill | (b << 5), "R8 ctrl write");
                step(0, 0, 1, A_CTRL, 0, "R7 ctrl readback");
            end
        end
        step(0, 1, 0, A_CTRL, 32'h0000_0060, "R8 back to back 1");
        step(0, 1, 0, A_CTRL, 32'h0000_0040, "R8 back to back 2");
        step(0, 0, 0, A_CTRL, 0, "R8 pulse ended");

        // R9: unmapped offsets
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ua;
            ua = 8'h30 + 8'(k * 12);
            if (ua == A_CTRL || ua == A_HI || ua == A_LO) ua = ua + 8'h04;
            step(0, 1, 0, ua, 32'hFFFF_FFFF, "R9 unmapped write");
            step(0, 0, 1, ua, 0, "R9 unmapped read");
        end
        step(0, 0, 1, A_LO, 0, "R9 lo untouched");
        step(0, 0, 1, A_HI, 0, "R9 hi untouched");
        step(0, 0, 1, A_CTRL, 0, "R9 ctrl untouched");

        // R1: full wrap of the counter
        step(0, 1, 0, A_HI, 32'h0000_000F, "R1 set top");
        step(0, 1, 0, A_LO, 32'hFFFF_FFFF, "R1 set bottom");
        step(1, 0, 0, A_LO, 0, "R1 wrap tick");
        step(0, 0, 1, A_LO, 0, "R1 wrap lo");
        step(0, 0, 1, A_HI, 0, "R1 wrap hi");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule